// File: doc/BRIEF.md
# Multi-source reset sequencer

This block combines every reset request on the chip into one core reset and stretches that reset to a fixed number of clock cycles. The requests are an active-low bidirectional reset pad, a static power-on/low-voltage level, a watchdog request and a safeguard monitor request. During every stretch the block pulls the pad low through an open-drain enable, so the whole board sees the reset. It reads the same pad back as the external request. Its own drive is masked so that the readback cannot restart the sequence. The pad must be seen high again before another external low counts.

The same counter provides an oscillator-settle delay in two cases: after power-on, and when a halt-exit strobe arrives. An external low that is still on the pad when a stretch ends keeps the core in reset until the pad is released. A sticky four-bit cause register records which sources started resets. A constant output gives the address of the restart vector.

The sequencer is a state machine with six states:

- POR: entered asynchronously while the power-on level is high.
- PWRUP: the power-up count, with the pad driven and the settle flag set.
- STRETCH: the reset count, with the pad driven.
- HOLD: the core stays in reset until the synchronized pad reads high.
- RUN: normal operation.
- SETTLE: the halt-exit count, with the core running.

The transitions are:

- POR→PWRUP when the power-on level drops.
- PWRUP→HOLD and STRETCH→HOLD at the terminal count.
- HOLD→RUN when the pad is seen high.
- RUN→STRETCH on any request; this has priority over the next transition.
- RUN→SETTLE on the halt-exit strobe.
- SETTLE→STRETCH on any request.
- SETTLE→RUN at the terminal count.
- Any state→POR, asynchronously.

Top module: `rstseq_top`

## Requirements
- R1: A qualified external low, a watchdog request or a safeguard request seen in RUN starts a reset. `core_rst_o` is high at the next clock edge.
- R2: During every reset count (PWRUP and STRETCH) `pad_pull_low_o` is high, and `core_rst_o` is high with it.
- R3: Each reset count keeps `pad_pull_low_o` high for exactly STRETCH_CYCLES (default 4096) clock cycles.
- R4: An external low is accepted only when two consecutive synchronized samples of `pad_level_i` are low. A low seen at only one clock edge is ignored.
- R5: When a count ends while the pad is still held low from outside, `core_rst_o` stays high with `pad_pull_low_o` low. `core_rst_o` falls at the third clock edge after the pad goes high.
- R6: The pad readback of the block's own drive does not start a new reset. After a stretch, `core_rst_o` stays low while the pad stays high.
- R7: While `por_lvd_i` is high, `core_rst_o` and `pad_pull_low_o` are high without waiting for a clock edge. After `por_lvd_i` falls, a STRETCH_CYCLES power-up count runs with `osc_settle_o` high.
- R8: A one-cycle `halt_exit_i` in RUN starts a count of STRETCH_CYCLES cycles. During it `osc_settle_o` is high, `core_rst_o` is low and `pad_pull_low_o` is low.
- R9: `cause_o` bit 0 marks an external reset, bit 1 power-on, bit 2 watchdog and bit 3 safeguard. The bits of all sources active when a reset starts are ORed in. Power-on sets the value to 4'b0010. `cause_clr_i` clears it to zero.
- R10: `reset_vector_o` is always 16'hFFFE.
- R11: A watchdog or safeguard request during SETTLE abandons the settle count and starts a reset stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| por_lvd_i | input | 1 | Power-on / low-voltage level, active high, asynchronous |
| pad_level_i | input | 1 | Sampled level of the reset pad |
| wdg_req_i | input | 1 | Watchdog reset request |
| safeguard_req_i | input | 1 | Safeguard monitor reset request |
| halt_exit_i | input | 1 | One-cycle strobe on leaving halt mode |
| cause_clr_i | input | 1 | Software clear of the cause register |
| pad_pull_low_o | output | 1 | Open-drain pull-low enable for the reset pad |
| core_rst_o | output | 1 | Chip-wide reset, active high |
| osc_settle_o | output | 1 | Oscillator-settle busy flag |
| cause_o | output | 4 | Sticky reset cause |
| reset_vector_o | output | 16 | Address of the restart vector |

## Verification
The hardest situations to reach are on the shared pad. One is an external low that outlasts the block's own drive across the end of a count. The other is the block reading back its own pull-low and having to ignore it. The bench models the pad as a wired-AND: the pad is low when either the design's pull-low or the bench's own drive is active. This makes the self-readback real rather than faked. The bench then holds its drive low through a whole power-up or stretch and releases it afterwards, and it also applies one-cycle and two-cycle lows to probe the two-sample qualification.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_POR,
        ST_PWRUP,
        ST_STRETCH,
        ST_HOLD,
        ST_RUN,
        ST_SETTLE
    } seq_state_t;

    localparam int CAUSE_W    = 4;
    localparam int CAUSE_EXT  = 0;
    localparam int CAUSE_POR  = 1;
    localparam int CAUSE_WDG  = 2;
    localparam int CAUSE_SAFE = 3;

    localparam logic [15:0] RESTART_VECTOR = 16'hFFFE;

endpackage

// File: rtl/rstseq_pad_qual.sv
module rstseq_pad_qual #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic pad_level_i,
    input  logic drive_i,
    output logic pad_high_o,
    output logic ext_req_o
);
    localparam int LAST = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  hist_q;
    logic                  armed_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= pad_level_i;
            for (int i = 1; i < SYNC_DEPTH; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            hist_q <= 1'b1;
        end else begin
            hist_q <= sync_q[LAST];
        end
    end

    // Own drive disarms; the pad must read high before a new low counts.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            armed_q <= 1'b0;
        end else if (drive_i) begin
            armed_q <= 1'b0;
        end else if (sync_q[LAST]) begin
            armed_q <= 1'b1;
        end
    end

    assign pad_high_o = sync_q[LAST];
    assign ext_req_o  = armed_q && !sync_q[LAST] && !hist_q;

    if (SYNC_DEPTH == 2) begin : g_chk
        // R4: an accepted request needs two low pad samples in a row
        p_two_samples_r4: assert property (@(posedge clk_i) disable iff (arst_i)
            ext_req_o |-> (!$past(pad_level_i, 2) && !$past(pad_level_i, 3)));
    end

endmodule

// File: rtl/rstseq_cnt.sv
module rstseq_cnt #(
    parameter int LIMIT = 4096
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int            CW       = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && (cnt_q != LAST_VAL)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done_o = en_i && (cnt_q == LAST_VAL);

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STRETCH_CYCLES = 4096,
    parameter int SYNC_DEPTH     = 2
) (
    input  logic               clk_i,
    input  logic               por_lvd_i,
    input  logic               pad_level_i,
    input  logic               wdg_req_i,
    input  logic               safeguard_req_i,
    input  logic               halt_exit_i,
    input  logic               cause_clr_i,
    output logic               pad_pull_low_o,
    output logic               core_rst_o,
    output logic               osc_settle_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [15:0]        reset_vector_o
);
    localparam int LW = $clog2(STRETCH_CYCLES + 1);

    seq_state_t         state_q, state_d;
    logic               ext_req, pad_high, cnt_done, cnt_en, cnt_clr;
    logic               any_req, start_rst;
    logic [CAUSE_W-1:0] cause_q, cause_d, new_cause;

    rstseq_pad_qual #(.SYNC_DEPTH(SYNC_DEPTH)) u_pad_qual (
        .clk_i       (clk_i),
        .arst_i      (por_lvd_i),
        .pad_level_i (pad_level_i),
        .drive_i     (pad_pull_low_o),
        .pad_high_o  (pad_high),
        .ext_req_o   (ext_req)
    );

    rstseq_cnt #(.LIMIT(STRETCH_CYCLES)) u_cnt (
        .clk_i  (clk_i),
        .arst_i (por_lvd_i),
        .clr_i  (cnt_clr),
        .en_i   (cnt_en),
        .done_o (cnt_done)
    );

    assign any_req = ext_req || wdg_req_i || safeguard_req_i;

    // State register: asynchronous entry into POR, synchronous exit
    always_ff @(posedge clk_i or posedge por_lvd_i) begin
        if (por_lvd_i) begin
            state_q <= ST_POR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:     state_d = ST_PWRUP;
            ST_PWRUP:   if (cnt_done) state_d = ST_HOLD;
            ST_STRETCH: if (cnt_done) state_d = ST_HOLD;
            ST_HOLD:    if (pad_high) state_d = ST_RUN;
            ST_RUN: begin
                if (any_req)          state_d = ST_STRETCH;
                else if (halt_exit_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (any_req)          state_d = ST_STRETCH;
                else if (cnt_done)    state_d = ST_RUN;
            end
            default:    state_d = ST_POR;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        pad_pull_low_o = 1'b0;
        core_rst_o     = 1'b1;
        osc_settle_o   = 1'b0;
        cnt_en         = 1'b0;
        unique case (state_q)
            ST_POR:     pad_pull_low_o = 1'b1;
            ST_PWRUP: begin
                pad_pull_low_o = 1'b1;
                osc_settle_o   = 1'b1;
                cnt_en         = 1'b1;
            end
            ST_STRETCH: begin
                pad_pull_low_o = 1'b1;
                cnt_en         = 1'b1;
            end
            ST_HOLD:    core_rst_o = 1'b1;
            ST_RUN:     core_rst_o = 1'b0;
            ST_SETTLE: begin
                core_rst_o   = 1'b0;
                osc_settle_o = 1'b1;
                cnt_en       = 1'b1;
            end
            default:    pad_pull_low_o = 1'b1;
        endcase
    end

    assign cnt_clr = (state_d != state_q);

    // Sticky cause register
    assign start_rst = ((state_q == ST_RUN) || (state_q == ST_SETTLE)) && (state_d == ST_STRETCH);

    always_comb begin
        new_cause                 = '0;
        new_cause[CAUSE_EXT]      = ext_req;
        new_cause[CAUSE_WDG]      = wdg_req_i;
        new_cause[CAUSE_SAFE]     = safeguard_req_i;
        cause_d = cause_clr_i ? '0 : cause_q;
        if (start_rst) begin
            cause_d = cause_d | new_cause;
        end
    end

    always_ff @(posedge clk_i or posedge por_lvd_i) begin
        if (por_lvd_i) begin
            cause_q <= CAUSE_W'(1 << CAUSE_POR);
        end else begin
            cause_q <= cause_d;
        end
    end

    assign cause_o        = cause_q;
    assign reset_vector_o = RESTART_VECTOR;

    // Checker: length of each reset count
    logic          in_count;
    logic [LW-1:0] count_len_q;

    assign in_count = (state_q == ST_PWRUP) || (state_q == ST_STRETCH);

    always_ff @(posedge clk_i or posedge por_lvd_i) begin
        if (por_lvd_i) begin
            count_len_q <= '0;
        end else if (in_count) begin
            count_len_q <= count_len_q + LW'(1);
        end else begin
            count_len_q <= '0;
        end
    end

    p_count_len_r3: assert property (@(posedge clk_i) disable iff (por_lvd_i)
        $fell(in_count) |-> (count_len_q == LW'(STRETCH_CYCLES)));

    p_req_starts_r1: assert property (@(posedge clk_i) disable iff (por_lvd_i)
        ((state_q == ST_RUN) && (wdg_req_i || safeguard_req_i)) |=> (core_rst_o && pad_pull_low_o));

    p_hold_keeps_r5: assert property (@(posedge clk_i) disable iff (por_lvd_i)
        ((state_q == ST_HOLD) && !pad_high) |=> core_rst_o);

    p_settle_src_r8: assert property (@(posedge clk_i) disable iff (por_lvd_i)
        ($rose(osc_settle_o) && !core_rst_o) |-> $past(halt_exit_i));

    p_cause_set_r9: assert property (@(posedge clk_i) disable iff (por_lvd_i)
        $rose(core_rst_o) |-> (cause_o != '0));

endmodule

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
    localparam int N = 4096;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        ext_low = 1'b0;
    logic        wdg = 1'b0;
    logic        sg = 1'b0;
    logic        halt_exit = 1'b0;
    logic        cause_clr = 1'b0;
    logic        pad_level;
    logic        pad_pull_low_o, core_rst_o, osc_settle_o;
    logic [3:0]  cause_o;
    logic [15:0] reset_vector_o;

    int checks = 0;
    int fails  = 0;
    int pull_total = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // wired-AND pad: low if the design or the bench pulls it
    assign pad_level = !(pad_pull_low_o || ext_low);

    always @(posedge clk) pull_total <= pull_total + (pad_pull_low_o ? 1 : 0);

    rstseq_top u_rstseq_top (
        .clk_i           (clk),
        .por_lvd_i       (por),
        .pad_level_i     (pad_level),
        .wdg_req_i       (wdg),
        .safeguard_req_i (sg),
        .halt_exit_i     (halt_exit),
        .cause_clr_i     (cause_clr),
        .pad_pull_low_o  (pad_pull_low_o),
        .core_rst_o      (core_rst_o),
        .osc_settle_o    (osc_settle_o),
        .cause_o         (cause_o),
        .reset_vector_o  (reset_vector_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_release();
        int guard = 0;
        while (core_rst_o && guard < 3 * N) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic clear_cause();
        @(negedge clk) cause_clr = 1'b1;
        @(negedge clk) cause_clr = 1'b0;
    endtask

    // {src[1:0], width[3:0], exp_rst, exp_cause[3:0]}; src 0 ext, 1 wdg, 2 safeguard, 3 wdg+safeguard
    localparam logic [10:0] VEC [7] = '{
        {2'd0, 4'd1, 1'b0, 4'b0000},
        {2'd0, 4'd2, 1'b1, 4'b0001},
        {2'd1, 4'd1, 1'b1, 4'b0100},
        {2'd2, 4'd1, 1'b1, 4'b1000},
        {2'd0, 4'd3, 1'b1, 4'b0001},
        {2'd3, 4'd1, 1'b1, 4'b1100},
        {2'd0, 4'd1, 1'b0, 4'b0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R7 por core_rst", core_rst_o, 1);
        chk("R7 por pull_low", pad_pull_low_o, 1);
        chk("R9 por cause", cause_o, 4'b0010);
        chk("R10 vector", reset_vector_o, 16'hFFFE);

        por = 1'b0;
        @(negedge clk);
        chk("R7 pwrup settle", osc_settle_o, 1);
        chk("R2 pwrup core_rst", core_rst_o, 1);
        n = 0;
        while (pad_pull_low_o && n < 3 * N) begin
            n++;
            @(negedge clk);
        end
        chk("R3 pwrup length", n, N);
        chk("R5 hold after pwrup", core_rst_o, 1);
        repeat (4) @(negedge clk);
        chk("R5 release after pwrup", core_rst_o, 0);
        chk("R9 cause after pwrup", cause_o, 4'b0010);

        // table-driven stimulus
        for (int i = 0; i < 7; i++) begin
            logic [1:0] src;
            int         w;
            int         base;
            src = VEC[i][10:9];
            w   = int'(VEC[i][8:5]);
            clear_cause();
            base = pull_total;
            @(negedge clk);
            case (src)
                2'd0: ext_low = 1'b1;
                2'd1: wdg = 1'b1;
                2'd2: sg = 1'b1;
                default: begin wdg = 1'b1; sg = 1'b1; end
            endcase
            repeat (w) @(negedge clk);
            ext_low = 1'b0; wdg = 1'b0; sg = 1'b0;
            repeat (4) @(negedge clk);
            chk($sformatf("R1 R4 vec%0d core_rst", i), core_rst_o, VEC[i][4]);
            chk($sformatf("R9 vec%0d cause", i), cause_o, VEC[i][3:0]);
            if (VEC[i][4]) begin
                chk($sformatf("R2 vec%0d pull_low", i), pad_pull_low_o, 1);
                wait_release();
                chk($sformatf("R3 vec%0d pull length", i), pull_total - base, N);
            end
            repeat (12) @(negedge clk);
            chk($sformatf("R6 vec%0d no retrigger", i), core_rst_o, 0);
        end

        // R5: external low held past the end of the count
        @(negedge clk) ext_low = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 ext held starts", core_rst_o, 1);
        while (pad_pull_low_o) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R5 held core_rst", core_rst_o, 1);
        chk("R5 held no drive", pad_pull_low_o, 0);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 released", core_rst_o, 0);

        // R9: sticky OR of two resets, then software clear
        clear_cause();
        @(negedge clk) wdg = 1'b1;
        @(negedge clk) wdg = 1'b0;
        wait_release();
        repeat (8) @(negedge clk);
        @(negedge clk) sg = 1'b1;
        @(negedge clk) sg = 1'b0;
        wait_release();
        repeat (8) @(negedge clk);
        chk("R9 sticky or", cause_o, 4'b1100);
        clear_cause();
        chk("R9 sw clear", cause_o, 4'b0000);

        // R8: halt-exit settle count
        @(negedge clk) halt_exit = 1'b1;
        @(negedge clk) halt_exit = 1'b0;
        chk("R8 settle flag", osc_settle_o, 1);
        chk("R8 core runs", core_rst_o, 0);
        chk("R8 pin free", pad_pull_low_o, 0);
        n = 0;
        while (osc_settle_o && n < 3 * N) begin
            n++;
            @(negedge clk);
        end
        chk("R8 settle length", n, N);

        // R11: watchdog during settle
        @(negedge clk) halt_exit = 1'b1;
        @(negedge clk) halt_exit = 1'b0;
        repeat (100) @(negedge clk);
        wdg = 1'b1;
        @(negedge clk) wdg = 1'b0;
        chk("R11 core_rst", core_rst_o, 1);
        chk("R11 settle dropped", osc_settle_o, 0);
        chk("R11 pull_low", pad_pull_low_o, 1);
        wait_release();
        repeat (8) @(negedge clk);

        // R7: asynchronous power-on mid-run
        @(negedge clk) por = 1'b1;
        #1;
        chk("R7 async core_rst", core_rst_o, 1);
        chk("R7 async pull_low", pad_pull_low_o, 1);
        chk("R9 por overwrites", cause_o, 4'b0010);
        @(negedge clk) por = 1'b0;
        wait_release();
        repeat (4) @(negedge clk);
        chk("R7 recovered", core_rst_o, 0);
        chk("R10 vector final", reset_vector_o, 16'hFFFE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule